// File: doc/BRIEF.md
# Local Interrupt Source Dispatcher

This block turns events from a processor core's three local interrupt sources (an internal timer and two external interrupt pins, called LINT0 and LINT1 here) into requests for the rest of the interrupt controller. Each source owns one 32-bit configuration entry that software writes through a simple write port. When a source signals an event, the block looks up that source's entry. If the entry is masked, nothing happens. Otherwise the block decodes the delivery mode. It either raises a direct processor signal (system-management interrupt, non-maskable interrupt or external interrupt), or it asks the priority core to set the entry's vector pending, together with the trigger mode that applies.

LINT0 also reports its falling edge. When LINT0 releases and its entry is fixed-mode and level-triggered, the block withdraws the pending vector and asks for a priority re-evaluation. In external-interrupt mode a release only asks for re-evaluation. Level triggering is honoured for the two pins only; a timer request is always edge-triggered. The priority core and the timer counter sit outside this block.

Top module: `lvt_dispatch`

## Requirements
- R1: After reset every output is low and every entry resets to 32'h0001_0000 (masked, fixed mode, vector 0), so events produce no output until an entry is written.
- R2: Entry fields: bit 16 is the mask, bit 15 selects level trigger, bits 10:8 hold the delivery mode, bits 7:0 hold the vector. A write with select 0, 1 or 2 loads the timer, LINT0 or LINT1 entry. Select 3 changes no entry.
- R3: An assertion event on a source whose entry has the mask bit set produces no output.
- R4: An unmasked fixed-mode (000) event raises set_o for one cycle, with set_vec_o equal to the entry's vector.
- R5: Mode 010 pulses smi_o, mode 100 pulses nmi_o and mode 111 pulses extint_o, and none of them raises set_o.
- R6: Mode 101 (INIT) and the undefined codes 001, 011 and 110 produce no output on an assertion event.
- R7: set_level_o is high with set_o only when the source is LINT0 or LINT1 and the entry's level bit is set. A timer request is always edge-triggered.
- R8: A LINT0 release with a fixed-mode, level-triggered entry raises clr_o and reeval_o together, with clr_vec_o equal to the entry's vector. With a fixed-mode, edge-triggered entry a release produces nothing.
- R9: A LINT0 release in external-interrupt mode raises reeval_o alone. A release in any other mode produces nothing. The release path ignores the mask bit.
- R10: One event is served per cycle, in this priority order: LINT1 event, LINT0 rise, LINT0 release, timer event. Lower-priority events in the same cycle are dropped.
- R11: Outputs are registered and appear one cycle after the event, for exactly one cycle. An event in the same cycle as a write to its entry uses the entry's old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Entry write strobe |
| wr_sel_i | input | 2 | Entry select: 0 timer, 1 LINT0, 2 LINT1 |
| wr_data_i | input | 32 | Entry write data |
| timer_evt_i | input | 1 | Timer expiry strobe |
| lint0_rise_i | input | 1 | LINT0 assertion strobe |
| lint0_fall_i | input | 1 | LINT0 release strobe |
| lint1_evt_i | input | 1 | LINT1 assertion strobe |
| smi_o | output | 1 | System-management interrupt pulse |
| nmi_o | output | 1 | Non-maskable interrupt pulse |
| extint_o | output | 1 | External interrupt pulse |
| set_o | output | 1 | Set-pending request to the priority core |
| set_vec_o | output | 8 | Vector of the set request |
| set_level_o | output | 1 | Set request is level-triggered |
| clr_o | output | 1 | Clear-pending request |
| clr_vec_o | output | 8 | Vector to clear |
| reeval_o | output | 1 | Priority re-evaluation request |

## Verification
Every output of this block is due in the cycle after the edge that samples the event, and stays for that single cycle only. An entry write takes effect at the same edge, so it first affects events one cycle later. The bench drives stimulus on the falling clock edge. A behavioural model updates its expected outputs and its entry copy on each rising edge, reading the entry before applying the write. All outputs are compared with the model on every falling edge, so a late, early or stretched pulse shows up in the cycle where it differs.

// File: rtl/lvt_pkg.sv
package lvt_pkg;
  localparam int VEC_W     = 8;
  localparam int ENTRY_W   = 32;
  localparam int NUM_SRC   = 3;
  localparam int SEL_W     = 2;
  localparam int MODE_LSB  = 8;
  localparam int LEVEL_BIT = 15;
  localparam int MASK_BIT  = 16;

  localparam int SRC_TIMER = 0;
  localparam int SRC_LINT0 = 1;
  localparam int SRC_LINT1 = 2;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'b000,
    DM_SMI    = 3'b010,
    DM_NMI    = 3'b100,
    DM_INIT   = 3'b101,
    DM_EXTINT = 3'b111
  } dmode_e;

  typedef enum logic [1:0] {
    EV_NONE    = 2'd0,
    EV_ASSERT  = 2'd1,
    EV_RELEASE = 2'd2
  } evkind_e;

  typedef struct packed {
    logic             mask;
    logic             level;
    logic [2:0]       mode;
    logic [VEC_W-1:0] vec;
  } lvt_entry_t;
endpackage

// File: rtl/lvt_table.sv
module lvt_table
  import lvt_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int SW    = SEL_W,
  parameter int DW    = ENTRY_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [SW-1:0] wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  output lvt_entry_t    entries_o [N_SRC]
);
  localparam lvt_entry_t RST_ENT = '{mask: 1'b1, level: 1'b0, mode: 3'b000, vec: '0};

  lvt_entry_t wr_ent;
  always_comb begin
    wr_ent.mask  = wr_data_i[MASK_BIT];
    wr_ent.level = wr_data_i[LEVEL_BIT];
    wr_ent.mode  = wr_data_i[MODE_LSB +: 3];
    wr_ent.vec   = wr_data_i[VEC_W-1:0];
  end

  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data_i[DW-1:MASK_BIT+1], wr_data_i[LEVEL_BIT-1:MODE_LSB+3]};

  for (genvar g = 0; g < N_SRC; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   entries_o[g] <= RST_ENT;
      else if (wr_en_i && (wr_sel_i == SW'(g)))      entries_o[g] <= wr_ent;
    end
  end

  // R2: a select beyond the table leaves every entry untouched
  a_r2_bad_sel_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (int'(wr_sel_i) >= N_SRC)) |=> $stable(entries_o[0]) && $stable(entries_o[N_SRC-1]));
endmodule

// File: rtl/lvt_arb.sv
module lvt_arb
  import lvt_pkg::*;
#(
  parameter int SW = SEL_W
) (
  input  logic          timer_evt_i,
  input  logic          lint0_rise_i,
  input  logic          lint0_fall_i,
  input  logic          lint1_evt_i,
  output evkind_e       kind_o,
  output logic [SW-1:0] src_o
);
  always_comb begin
    kind_o = EV_NONE;
    src_o  = SW'(SRC_TIMER);
    if (lint1_evt_i) begin
      kind_o = EV_ASSERT;
      src_o  = SW'(SRC_LINT1);
    end else if (lint0_rise_i) begin
      kind_o = EV_ASSERT;
      src_o  = SW'(SRC_LINT0);
    end else if (lint0_fall_i) begin
      kind_o = EV_RELEASE;
      src_o  = SW'(SRC_LINT0);
    end else if (timer_evt_i) begin
      kind_o = EV_ASSERT;
      src_o  = SW'(SRC_TIMER);
    end
  end
endmodule

// File: rtl/lvt_decode.sv
module lvt_decode
  import lvt_pkg::*;
#(
  parameter int SW = SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  evkind_e          kind_i,
  input  logic [SW-1:0]    src_i,
  input  lvt_entry_t       ent_i,
  output logic             smi_o,
  output logic             nmi_o,
  output logic             extint_o,
  output logic             set_o,
  output logic [VEC_W-1:0] set_vec_o,
  output logic             set_level_o,
  output logic             clr_o,
  output logic [VEC_W-1:0] clr_vec_o,
  output logic             reeval_o
);
  logic             smi_d, nmi_d, ext_d, set_d, lvl_d, clr_d, rev_d;
  logic             is_pin;

  assign is_pin = (src_i == SW'(SRC_LINT0)) || (src_i == SW'(SRC_LINT1));

  always_comb begin
    smi_d = 1'b0; nmi_d = 1'b0; ext_d = 1'b0;
    set_d = 1'b0; lvl_d = 1'b0; clr_d = 1'b0; rev_d = 1'b0;
    if (kind_i == EV_ASSERT && !ent_i.mask) begin
      unique case (ent_i.mode)
        DM_FIXED:  begin set_d = 1'b1; lvl_d = is_pin && ent_i.level; end
        DM_SMI:    smi_d = 1'b1;
        DM_NMI:    nmi_d = 1'b1;
        DM_EXTINT: ext_d = 1'b1;
        default:   ;
      endcase
    end else if (kind_i == EV_RELEASE) begin
      // release path is not gated by the mask
      if (ent_i.mode == DM_FIXED && ent_i.level) begin
        clr_d = 1'b1; rev_d = 1'b1;
      end else if (ent_i.mode == DM_EXTINT) begin
        rev_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smi_o <= 1'b0; nmi_o <= 1'b0; extint_o <= 1'b0;
      set_o <= 1'b0; set_level_o <= 1'b0; set_vec_o <= '0;
      clr_o <= 1'b0; clr_vec_o <= '0; reeval_o <= 1'b0;
    end else begin
      smi_o       <= smi_d;
      nmi_o       <= nmi_d;
      extint_o    <= ext_d;
      set_o       <= set_d;
      set_level_o <= lvl_d;
      clr_o       <= clr_d;
      reeval_o    <= rev_d;
      if (set_d) set_vec_o <= ent_i.vec;
      if (clr_d) clr_vec_o <= ent_i.vec;
    end
  end

  a_r3_masked_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == EV_ASSERT && ent_i.mask) |=> !(smi_o || nmi_o || extint_o || set_o));
  a_r7_timer_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == EV_ASSERT && src_i == SW'(SRC_TIMER)) |=> !set_level_o);
  a_r7_level_needs_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_level_o |-> set_o);
  a_r8_clr_with_reeval: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |-> reeval_o);
  a_r9_release_no_signal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == EV_RELEASE) |=> !(smi_o || nmi_o || extint_o || set_o));
  a_r11_one_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({smi_o, nmi_o, extint_o, set_o, reeval_o}));
endmodule

// File: rtl/lvt_dispatch.sv
module lvt_dispatch
  import lvt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [SEL_W-1:0]   wr_sel_i,
  input  logic [ENTRY_W-1:0] wr_data_i,
  input  logic               timer_evt_i,
  input  logic               lint0_rise_i,
  input  logic               lint0_fall_i,
  input  logic               lint1_evt_i,
  output logic               smi_o,
  output logic               nmi_o,
  output logic               extint_o,
  output logic               set_o,
  output logic [VEC_W-1:0]   set_vec_o,
  output logic               set_level_o,
  output logic               clr_o,
  output logic [VEC_W-1:0]   clr_vec_o,
  output logic               reeval_o
);
  lvt_entry_t         entries [NUM_SRC];
  lvt_entry_t         sel_ent;
  evkind_e            kind;
  logic [SEL_W-1:0]   src;

  lvt_table #(.N_SRC(NUM_SRC), .SW(SEL_W), .DW(ENTRY_W)) u_table (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i, .entries_o(entries)
  );

  lvt_arb #(.SW(SEL_W)) u_arb (
    .timer_evt_i, .lint0_rise_i, .lint0_fall_i, .lint1_evt_i,
    .kind_o(kind), .src_o(src)
  );

  always_comb begin
    sel_ent = entries[0];
    for (int i = 0; i < NUM_SRC; i++)
      if (src == SEL_W'(i)) sel_ent = entries[i];
  end

  lvt_decode #(.SW(SEL_W)) u_dec (
    .clk_i, .rst_ni, .kind_i(kind), .src_i(src), .ent_i(sel_ent),
    .smi_o, .nmi_o, .extint_o, .set_o, .set_vec_o, .set_level_o,
    .clr_o, .clr_vec_o, .reeval_o
  );

  // R10: a LINT1 event pre-empts any LINT0 release in the same cycle
  a_r10_lint1_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lint1_evt_i |=> !clr_o);
endmodule

// File: tb/lvt_dispatch_tb_top.sv
module lvt_dispatch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        t_ev = 1'b0, r0 = 1'b0, f0 = 1'b0, l1 = 1'b0;
  logic        smi, nmi, ext, set, lvl, clr, rev;
  logic [7:0]  svec, cvec;

  always #5 clk = ~clk;

  lvt_dispatch dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .timer_evt_i(t_ev), .lint0_rise_i(r0), .lint0_fall_i(f0), .lint1_evt_i(l1),
    .smi_o(smi), .nmi_o(nmi), .extint_o(ext), .set_o(set), .set_vec_o(svec),
    .set_level_o(lvl), .clr_o(clr), .clr_vec_o(cvec), .reeval_o(rev)
  );

  int checks = 0, errors = 0;
  string cur_req = "R1";

  // behavioural model
  logic [31:0] ent [3];
  logic        e_smi, e_nmi, e_ext, e_set, e_lvl, e_clr, e_rev;
  logic [7:0]  e_svec, e_cvec;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) ent[i] = 32'h0001_0000;
      {e_smi, e_nmi, e_ext, e_set, e_lvl, e_clr, e_rev} = '0;
      e_svec = '0; e_cvec = '0;
    end else begin
      int src; int kind; logic [31:0] e;
      {e_smi, e_nmi, e_ext, e_set, e_lvl, e_clr, e_rev} = '0;
      kind = 0; src = 0;
      if (l1) begin kind = 1; src = 2; end
      else if (r0) begin kind = 1; src = 1; end
      else if (f0) begin kind = 2; src = 1; end
      else if (t_ev) begin kind = 1; src = 0; end
      e = ent[src];
      if (kind == 1 && !e[16]) begin
        case (e[10:8])
          3'd0: begin e_set = 1; e_svec = e[7:0]; e_lvl = (src != 0) && e[15]; end
          3'd2: e_smi = 1;
          3'd4: e_nmi = 1;
          3'd7: e_ext = 1;
          default: ;
        endcase
      end else if (kind == 2) begin
        if (e[10:8] == 3'd0 && e[15]) begin e_clr = 1; e_rev = 1; e_cvec = e[7:0]; end
        else if (e[10:8] == 3'd7) e_rev = 1;
      end
      if (wr_en && wr_sel != 2'd3) ent[wr_sel] = wr_data;
    end
  end

  always @(negedge clk) if (rst_n) begin
    logic [22:0] act, exp;
    act = {smi, nmi, ext, set, lvl, clr, rev, svec, cvec};
    exp = {e_smi, e_nmi, e_ext, e_set, e_lvl, e_clr, e_rev, e_svec, e_cvec};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h (smi nmi ext set lvl clr rev svec cvec)", cur_req, act, exp);
    end
  end

  function automatic logic [31:0] mk(bit m, bit lv, logic [2:0] md, logic [7:0] v);
    return {15'd0, m, lv, 4'd0, md, v};
  endfunction

  task automatic step(bit we, logic [1:0] s, logic [31:0] d, bit t, bit r, bit f, bit b);
    wr_en = we; wr_sel = s; wr_data = d; t_ev = t; r0 = r; f0 = f; l1 = b;
    @(negedge clk);
    wr_en = 0; t_ev = 0; r0 = 0; f0 = 0; l1 = 0;
  endtask

  task automatic wr(logic [1:0] s, logic [31:0] d);
    step(1, s, d, 0, 0, 0, 0);
  endtask

  task automatic fire_all;
    step(0, 0, 0, 1, 0, 0, 0); step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0); step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1); step(0, 0, 0, 0, 0, 0, 0);
  endtask

  bit done = 0;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1"; fire_all(); step(0, 0, 0, 0, 0, 1, 0); step(0, 0, 0, 0, 0, 0, 0);
    cur_req = "R4";
    wr(0, mk(0, 0, 3'd0, 8'h41)); wr(1, mk(0, 0, 3'd0, 8'h52)); wr(2, mk(0, 0, 3'd0, 8'h63));
    fire_all();
    cur_req = "R2"; wr(3, mk(0, 0, 3'd0, 8'hEE)); fire_all();
    cur_req = "R3"; wr(2, mk(1, 0, 3'd0, 8'h70)); wr(0, mk(1, 0, 3'd4, 8'h10)); fire_all();
    cur_req = "R5";
    wr(0, mk(0, 0, 3'd2, 8'h01)); wr(1, mk(0, 0, 3'd4, 8'h02)); wr(2, mk(0, 0, 3'd7, 8'h03));
    fire_all();
    cur_req = "R6";
    wr(0, mk(0, 0, 3'd5, 8'h11)); wr(1, mk(0, 0, 3'd1, 8'h12)); wr(2, mk(0, 0, 3'd3, 8'h13));
    fire_all();
    wr(1, mk(0, 0, 3'd6, 8'h14)); fire_all();
    cur_req = "R7";
    wr(0, mk(0, 1, 3'd0, 8'h21)); wr(1, mk(0, 1, 3'd0, 8'h22)); wr(2, mk(0, 1, 3'd0, 8'h23));
    fire_all();
    cur_req = "R8";
    step(0, 0, 0, 0, 0, 1, 0); step(0, 0, 0, 0, 0, 0, 0);
    wr(1, mk(0, 0, 3'd0, 8'h24)); step(0, 0, 0, 0, 0, 1, 0); step(0, 0, 0, 0, 0, 0, 0);
    cur_req = "R9";
    wr(1, mk(0, 0, 3'd7, 8'h25)); step(0, 0, 0, 0, 0, 1, 0);
    wr(1, mk(0, 0, 3'd4, 8'h26)); step(0, 0, 0, 0, 0, 1, 0);
    wr(1, mk(1, 1, 3'd0, 8'h27)); step(0, 0, 0, 0, 0, 1, 0); step(0, 0, 0, 0, 0, 0, 0);
    cur_req = "R10";
    wr(0, mk(0, 0, 3'd0, 8'h31)); wr(1, mk(0, 1, 3'd0, 8'h32)); wr(2, mk(0, 0, 3'd4, 8'h33));
    step(0, 0, 0, 1, 1, 1, 1); step(0, 0, 0, 1, 1, 1, 0);
    step(0, 0, 0, 1, 0, 1, 0); step(0, 0, 0, 1, 0, 0, 0); step(0, 0, 0, 0, 0, 0, 0);
    cur_req = "R11";
    step(0, 0, 0, 1, 0, 0, 0); step(0, 0, 0, 1, 0, 0, 0); step(0, 0, 0, 0, 1, 0, 0);
    step(1, 0, mk(0, 0, 3'd0, 8'h99), 1, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0); step(0, 0, 0, 0, 0, 0, 0); step(0, 0, 0, 0, 0, 0, 0);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin @(posedge clk); cyc++; end
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=timeout exp=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule